// File: doc/BRIEF.md
# Programmable Byte-Lane Swap Unit

This block reorders the four byte lanes of 32-bit words moving between a system bus and a processing engine. For every output byte, software picks which input lane supplies it. Each select is independent, so the unit can apply any permutation of the lanes. It can also copy one lane into several output bytes.

Two data paths run side by side. The host path carries accesses that the bus host starts. The master path carries transfers that the engine starts. Each path has its own set of four lane selects, its own valid signal and its own enable input. Both select sets live in one configuration register. That register is reached through a small request/response port and is always read and written without any swapping.

The register port is driven by a two-state machine:
- **CFG_IDLE** accepts requests and holds `cfg_ready` high.
  - A write in CFG_IDLE updates the register at the clock edge. The machine stays in CFG_IDLE (transition IDLE_WRITE).
  - A read in CFG_IDLE moves the machine to **CFG_RESP** (transition IDLE_TO_RESP).
- **CFG_RESP** presents the read data with `cfg_rvalid` high and `cfg_ready` low for one cycle. It then always returns to CFG_IDLE (transition RESP_TO_IDLE).
- With no request, CFG_IDLE stays where it is (transition IDLE_HOLD).

Top module: `byte_lane_steer`

## Requirements
- R1: After reset the configuration register reads 0x00E400E4. Both select fields then hold 0xE4, the identity mapping. After reset `cfg_ready` is 1 and both `*_out_valid` outputs are 0.
- R2: On the host path, output byte n (bits 8n+7:8n) takes input lane `cfg[16+2n+1:16+2n]`. The code 00 selects lane 0 (bits 7:0), 01 lane 1, 10 lane 2 and 11 lane 3.
- R3: On the master path, output byte n takes input lane `cfg[2n+1:2n]`, with the same codes as R2.
- R4: Several output bytes may name the same source lane. For example, select 0x00 copies lane 0 into all four bytes, and 0xFF copies lane 3 into all four bytes.
- R5: Bits 31:24 and 15:8 of the register ignore writes and always read as zero.
- R6: When a path's enable input is 0, its output word equals its input word whatever the select settings are.
- R7: Each path has exactly one register stage. `*_out_valid` equals the previous cycle's `*_in_valid`. The output data changes only on a cycle after a valid input beat.
- R8: A beat presented in the same cycle as a register write uses the old selects. A beat presented in the cycle after the write uses the new selects.
- R9: The register is written and read back without swapping. Any value in the select fields reads back bit-exact, whatever the enables and the current selects are.
- R10: A read request accepted while `cfg_ready` is 1 gives `cfg_rvalid`=1 and `cfg_ready`=0 in the next cycle, with the data on `cfg_rdata`. `cfg_rvalid` is never high in two consecutive cycles, and `cfg_rdata` is zero when `cfg_rvalid` is 0.
- R11: The host selects have no effect on the master path, and the master selects have no effect on the host path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Register access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_wdata | input | 32 | Register write data |
| cfg_ready | output | 1 | Port can accept a request (state CFG_IDLE) |
| cfg_rvalid | output | 1 | Read data valid (state CFG_RESP) |
| cfg_rdata | output | 32 | Register read data |
| host_en | input | 1 | Host path swap enable |
| host_in_valid | input | 1 | Host input beat valid |
| host_in_data | input | 32 | Host input word |
| host_out_valid | output | 1 | Host output beat valid |
| host_out_data | output | 32 | Host output word |
| mst_en | input | 1 | Master path swap enable |
| mst_in_valid | input | 1 | Master input beat valid |
| mst_in_data | input | 32 | Master input word |
| mst_out_valid | output | 1 | Master output beat valid |
| mst_out_data | output | 32 | Master output word |

## Verification
The data words used in the tests have four distinct byte values, so each output byte shows which lane it came from.
- The full reversal and several rotations check that each select reaches the right byte on each path (R2, R3).
- The all-zero and all-ones select patterns separate true replication from a mapping that only permutes lanes (R4).
- With one path reversed and the other at identity, any leak of one path's selects into the other path becomes visible (R11).
- A write issued in the same cycle as a beat, followed by a second beat, shows at which edge new selects take effect (R8).

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    localparam int unsigned LSW_LANES    = 4;
    localparam int unsigned LSW_LANE_W   = 8;
    localparam int unsigned LSW_SEL_W    = $clog2(LSW_LANES);
    localparam int unsigned LSW_WORD_W   = LSW_LANES * LSW_LANE_W;
    localparam int unsigned LSW_SELS_W   = LSW_LANES * LSW_SEL_W;
    localparam int unsigned LSW_HOST_LSB = 16;
    localparam int unsigned LSW_MST_LSB  = 0;

    typedef enum logic [0:0] {
        CFG_IDLE = 1'b0,
        CFG_RESP = 1'b1
    } cfg_state_e;

    // Select set in which every output byte takes its own lane.
    function automatic logic [LSW_SELS_W-1:0] identity_sels();
        logic [LSW_SELS_W-1:0] s;
        s = '0;
        for (int i = 0; i < int'(LSW_LANES); i++) begin
            s[i*LSW_SEL_W +: LSW_SEL_W] = LSW_SEL_W'(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/lsw_cfg_reg.sv
module lsw_cfg_reg
    import lsw_pkg::*;
#(
    parameter int unsigned WORD_W   = LSW_WORD_W,
    parameter int unsigned SELS_W   = LSW_SELS_W,
    parameter int unsigned HOST_LSB = LSW_HOST_LSB,
    parameter int unsigned MST_LSB  = LSW_MST_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata,
    output logic [SELS_W-1:0] host_sel,
    output logic [SELS_W-1:0] mst_sel
);

    localparam logic [SELS_W-1:0] RST_SEL = SELS_W'(identity_sels());

    cfg_state_e        state_q, state_d;
    logic [SELS_W-1:0] host_sel_q, mst_sel_q;
    logic              accept;
    logic [WORD_W-1:0] reg_image;

    assign accept = req && (state_q == CFG_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: begin
                if (accept && !we) begin
                    state_d = CFG_RESP;      // IDLE_TO_RESP
                end else begin
                    state_d = CFG_IDLE;      // IDLE_WRITE / IDLE_HOLD
                end
            end
            CFG_RESP: begin
                state_d = CFG_IDLE;          // RESP_TO_IDLE
            end
            default: state_d = CFG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Select storage: only the two select fields are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_sel_q <= RST_SEL;
            mst_sel_q  <= RST_SEL;
        end else if (accept && we) begin
            host_sel_q <= wdata[HOST_LSB +: SELS_W];
            mst_sel_q  <= wdata[MST_LSB  +: SELS_W];
        end
    end

    // Register image: unused bits tie to zero
    always_comb begin
        reg_image = '0;
        reg_image[HOST_LSB +: SELS_W] = host_sel_q;
        reg_image[MST_LSB  +: SELS_W] = mst_sel_q;
    end

    // Outputs decoded from the state
    always_comb begin
        ready  = 1'b0;
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            CFG_IDLE: begin
                ready = 1'b1;
            end
            CFG_RESP: begin
                rvalid = 1'b1;
                rdata  = reg_image;
            end
            default: ready = 1'b0;
        endcase
    end

    assign host_sel = host_sel_q;
    assign mst_sel  = mst_sel_q;

endmodule

// File: rtl/lsw_lane_mux.sv
module lsw_lane_mux #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned SEL_W  = $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES*SEL_W-1:0]  sel,
    output logic [LANES*LANE_W-1:0] dout
);

    for (genvar g = 0; g < int'(LANES); g++) begin : g_out_byte
        logic [SEL_W-1:0]  src;
        logic [LANE_W-1:0] pick;

        assign src = sel[g*SEL_W +: SEL_W];

        always_comb begin
            pick = '0;
            for (int s = 0; s < int'(LANES); s++) begin
                if (src == SEL_W'(s)) begin
                    pick = din[s*LANE_W +: LANE_W];
                end
            end
        end

        assign dout[g*LANE_W +: LANE_W] = pick;
    end

endmodule

// File: rtl/lsw_path.sv
module lsw_path #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned SEL_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [LANES*SEL_W-1:0]  sel,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data
);

    localparam int unsigned WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] steered;
    logic [WORD_W-1:0] next_word;
    logic              valid_q;
    logic [WORD_W-1:0] data_q;

    lsw_lane_mux #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .SEL_W  (SEL_W)
    ) u_mux (
        .din  (in_data),
        .sel  (sel),
        .dout (steered)
    );

    assign next_word = en ? steered : in_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                data_q <= next_word;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_data  = data_q;

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
    import lsw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_req,
    input  logic                  cfg_we,
    input  logic [LSW_WORD_W-1:0] cfg_wdata,
    output logic                  cfg_ready,
    output logic                  cfg_rvalid,
    output logic [LSW_WORD_W-1:0] cfg_rdata,
    input  logic                  host_en,
    input  logic                  host_in_valid,
    input  logic [LSW_WORD_W-1:0] host_in_data,
    output logic                  host_out_valid,
    output logic [LSW_WORD_W-1:0] host_out_data,
    input  logic                  mst_en,
    input  logic                  mst_in_valid,
    input  logic [LSW_WORD_W-1:0] mst_in_data,
    output logic                  mst_out_valid,
    output logic [LSW_WORD_W-1:0] mst_out_data
);

    logic [LSW_SELS_W-1:0] host_sel;
    logic [LSW_SELS_W-1:0] mst_sel;

    lsw_cfg_reg #(
        .WORD_W   (LSW_WORD_W),
        .SELS_W   (LSW_SELS_W),
        .HOST_LSB (LSW_HOST_LSB),
        .MST_LSB  (LSW_MST_LSB)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cfg_req),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .ready    (cfg_ready),
        .rvalid   (cfg_rvalid),
        .rdata    (cfg_rdata),
        .host_sel (host_sel),
        .mst_sel  (mst_sel)
    );

    lsw_path #(
        .LANES  (LSW_LANES),
        .LANE_W (LSW_LANE_W),
        .SEL_W  (LSW_SEL_W)
    ) u_host_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (host_en),
        .sel       (host_sel),
        .in_valid  (host_in_valid),
        .in_data   (host_in_data),
        .out_valid (host_out_valid),
        .out_data  (host_out_data)
    );

    lsw_path #(
        .LANES  (LSW_LANES),
        .LANE_W (LSW_LANE_W),
        .SEL_W  (LSW_SEL_W)
    ) u_mst_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mst_en),
        .sel       (mst_sel),
        .in_valid  (mst_in_valid),
        .in_data   (mst_in_data),
        .out_valid (mst_out_valid),
        .out_data  (mst_out_data)
    );

endmodule

// File: rtl/byte_lane_steer_chk.sv
module byte_lane_steer_chk
    import lsw_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_req,
    input logic                  cfg_we,
    input logic                  cfg_ready,
    input logic                  cfg_rvalid,
    input logic [LSW_WORD_W-1:0] cfg_rdata,
    input logic                  host_en,
    input logic                  host_in_valid,
    input logic [LSW_WORD_W-1:0] host_in_data,
    input logic                  host_out_valid,
    input logic [LSW_WORD_W-1:0] host_out_data,
    input logic                  mst_en,
    input logic                  mst_in_valid,
    input logic [LSW_WORD_W-1:0] mst_in_data,
    input logic                  mst_out_valid,
    input logic [LSW_WORD_W-1:0] mst_out_data
);

    localparam logic [LSW_WORD_W-1:0] LIVE_MASK =
        (LSW_WORD_W'({LSW_SELS_W{1'b1}}) << LSW_HOST_LSB) |
        (LSW_WORD_W'({LSW_SELS_W{1'b1}}) << LSW_MST_LSB);

    // R7
    host_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> host_out_valid == $past(host_in_valid));

    // R7
    mst_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mst_out_valid == $past(mst_in_valid));

    // R6
    host_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_in_valid && !host_en |=> host_out_data == $past(host_in_data));

    // R6
    mst_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_in_valid && !mst_en |=> mst_out_data == $past(mst_in_data));

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~LIVE_MASK) == '0);

    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_we && cfg_ready |=> cfg_rvalid && !cfg_ready);

    // R10
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |=> !cfg_rvalid);

endmodule

bind byte_lane_steer byte_lane_steer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_req        (cfg_req),
    .cfg_we         (cfg_we),
    .cfg_ready      (cfg_ready),
    .cfg_rvalid     (cfg_rvalid),
    .cfg_rdata      (cfg_rdata),
    .host_en        (host_en),
    .host_in_valid  (host_in_valid),
    .host_in_data   (host_in_data),
    .host_out_valid (host_out_valid),
    .host_out_data  (host_out_data),
    .mst_en         (mst_en),
    .mst_in_valid   (mst_in_valid),
    .mst_in_data    (mst_in_data),
    .mst_out_valid  (mst_out_valid),
    .mst_out_data   (mst_out_data)
);

// File: tb/byte_lane_steer_bench.sv
`timescale 1ns/1ps
module byte_lane_steer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ready, cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        host_en = 1'b0, host_in_valid = 1'b0;
    logic [31:0] host_in_data = '0;
    logic        host_out_valid;
    logic [31:0] host_out_data;
    logic        mst_en = 1'b0, mst_in_valid = 1'b0;
    logic [31:0] mst_in_data = '0;
    logic        mst_out_valid;
    logic [31:0] mst_out_data;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    byte_lane_steer u_byte_lane_steer (
        .clk(clk), .rst_n(rst_n),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_ready(cfg_ready), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .host_en(host_en), .host_in_valid(host_in_valid), .host_in_data(host_in_data),
        .host_out_valid(host_out_valid), .host_out_data(host_out_data),
        .mst_en(mst_en), .mst_in_valid(mst_in_valid), .mst_in_data(mst_in_data),
        .mst_out_valid(mst_out_valid), .mst_out_data(mst_out_data)
    );

    // Spec model: output byte n takes lane sel[2n+1:2n]
    function automatic logic [31:0] steer(input logic [31:0] d, input logic [7:0] s);
        logic [31:0] r;
        for (int n = 0; n < 4; n++) begin
            r[8*n +: 8] = d[8*s[2*n +: 2] +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(output logic [31:0] v);
        cfg_req = 1'b1; cfg_we = 1'b0;
        @(negedge clk);
        cfg_req = 1'b0;
        check("R10 rvalid after read", 32'(cfg_rvalid), 32'd1);
        check("R10 ready low in response", 32'(cfg_ready), 32'd0);
        v = cfg_rdata;
        @(negedge clk);
        check("R10 ready back high", 32'(cfg_ready), 32'd1);
        check("R10 rdata zero when idle", cfg_rdata, 32'd0);
    endtask

    task automatic beat(input logic [31:0] hd, input logic he, input logic hv,
                        input logic [31:0] md, input logic me, input logic mv);
        host_in_data = hd; host_en = he; host_in_valid = hv;
        mst_in_data  = md; mst_en  = me; mst_in_valid  = mv;
        @(negedge clk);
        host_in_valid = 1'b0; mst_in_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 ready after reset", 32'(cfg_ready), 32'd1);
        check("R1 host valid after reset", 32'(host_out_valid), 32'd0);
        check("R1 master valid after reset", 32'(mst_out_valid), 32'd0);
        cfg_read(v);
        check("R1 reset value", v, 32'h00E4_00E4);
        beat(32'h4433_2211, 1'b1, 1'b1, 32'h8877_6655, 1'b1, 1'b1);
        check("R1 host identity", host_out_data, 32'h4433_2211);
        check("R1 master identity", mst_out_data, 32'h8877_6655);
    endtask

    task automatic t_host_map();
        logic [7:0] pats [4] = '{8'h1B, 8'h39, 8'h93, 8'h4E};
        foreach (pats[i]) begin
            cfg_write({8'h00, pats[i], 8'h00, 8'hE4});
            beat(32'hA1B2_C3D4, 1'b1, 1'b1, 32'h1020_3040, 1'b1, 1'b1);
            check("R2 host select", host_out_data, steer(32'hA1B2_C3D4, pats[i]));
            check("R11 master unaffected", mst_out_data, 32'h1020_3040);
        end
    endtask

    task automatic t_mst_map();
        logic [7:0] pats [4] = '{8'h1B, 8'h39, 8'h93, 8'hB1};
        foreach (pats[i]) begin
            cfg_write({8'h00, 8'hE4, 8'h00, pats[i]});
            beat(32'h0F1E_2D3C, 1'b1, 1'b1, 32'h5566_7788, 1'b1, 1'b1);
            check("R3 master select", mst_out_data, steer(32'h5566_7788, pats[i]));
            check("R11 host unaffected", host_out_data, 32'h0F1E_2D3C);
        end
    endtask

    task automatic t_replicate();
        cfg_write(32'h0000_00FF);
        beat(32'h1122_3344, 1'b1, 1'b1, 32'h1122_3344, 1'b1, 1'b1);
        check("R4 host lane0 copy", host_out_data, 32'h4444_4444);
        check("R4 master lane3 copy", mst_out_data, 32'h1111_1111);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        cfg_write(32'hFFFF_FFFF);
        cfg_read(v);
        check("R5 reserved bits zero", v, 32'h00FF_00FF);
    endtask

    task automatic t_enable();
        cfg_write(32'h001B_001B);
        beat(32'hDEAD_BEEF, 1'b0, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b1);
        check("R6 host bypass", host_out_data, 32'hDEAD_BEEF);
        check("R6 master bypass", mst_out_data, 32'hCAFE_F00D);
        beat(32'hDEAD_BEEF, 1'b1, 1'b1, 32'hCAFE_F00D, 1'b1, 1'b1);
        check("R6 host enabled swaps", host_out_data, 32'hEFBE_ADDE);
    endtask

    task automatic t_latency();
        beat(32'h0102_0304, 1'b1, 1'b1, 32'h0506_0708, 1'b1, 1'b1);
        check("R7 host valid one cycle", 32'(host_out_valid), 32'd1);
        beat(32'hFFFF_0000, 1'b1, 1'b0, 32'h0000_FFFF, 1'b1, 1'b0);
        check("R7 host valid drops", 32'(host_out_valid), 32'd0);
        check("R7 host data held", host_out_data, 32'h0403_0201);
        check("R7 master data held", mst_out_data, 32'h0807_0605);
    endtask

    task automatic t_write_timing();
        cfg_write(32'h00E4_00E4);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_wdata = 32'h001B_00E4;
        host_in_data = 32'h1122_3344; host_en = 1'b1; host_in_valid = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
        check("R8 beat with write uses old", host_out_data, 32'h1122_3344);
        host_in_data = 32'hAABB_CCDD;
        @(negedge clk);
        host_in_valid = 1'b0;
        check("R8 next beat uses new", host_out_data, 32'hDDCC_BBAA);
    endtask

    task automatic t_raw_cfg();
        logic [31:0] v;
        cfg_write(32'h001B_001B);
        host_en = 1'b1; mst_en = 1'b1;
        cfg_write(32'h0039_004E);
        cfg_read(v);
        check("R9 register not swapped", v, 32'h0039_004E);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_map();
        t_mst_map();
        t_replicate();
        t_reserved();
        t_enable();
        t_latency();
        t_write_timing();
        t_raw_cfg();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule